// File: doc/BRIEF.md
# Supply Fault Monitor with Event Latch

This block turns the digital outputs of two external supply-voltage comparators into a fault report for the rest of the system. Each channel can be set to treat its comparator as an undervoltage detector or as an overvoltage detector. Whenever any channel is in fault, the block pulls an active-low, open-drain fault line. A configuration bit can silence that line while the supply is being margined high or low. The Off and Nominal margin states are never silenced. A separate enable tells downstream hold-off and shutdown logic that it may act, and it is given only in the Nominal margin state.

A shared open-drain ready line signals that the supply has reached its set point, with programmable polarity. When the line is set to active-high, other devices can pull it low. That edge is used as a common capture instant, so several monitors on one board can freeze their comparator states at the same moment. The capture event is chosen by configuration. It is either the fault line asserting or the ready line falling. A host reads a 4-bit status word that holds live and captured per-channel fault bits. The host clears the captured bits with a one-cycle strobe.

All ports are plain control and status signals. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. The comparator inputs and the sampled ready pin are treated as asynchronous and are synchronized inside the block.

Top module: `supply_fault_monitor`

## Requirements
- R1: A channel with `cfg_ov_i[i]=1` is in fault when `cmp_i[i]=1` (input above reference). With `cfg_ov_i[i]=0` it is in fault when `cmp_i[i]=0` (input below reference). `status_o[i]` (bit 0 = channel 0, bit 1 = channel 1) shows the live fault state, 1 = fault, within four clock cycles of a stable input change.
- R2: `fault_oe_o=1` (drive the fault line low) while at least one channel is in fault and the line is not silenced. It returns to 0 once no channel is in fault.
- R3: With `cfg_mute_margin_i=1` and `margin_state_i` equal to 2 (margin high) or 3 (margin low), `fault_oe_o` stays 0. In states 0 (Off) and 1 (Nominal), or with the bit clear, nothing is silenced. Silencing never changes `status_o[1:0]`.
- R4: `holdoff_en_o` is 1 one cycle after `margin_state_i` is 1 (Nominal) and 0 otherwise.
- R5: The ready line is asserted when `at_target_i=1`. With `cfg_rdy_high_i=1` the line is active-high, so `rdy_oe_o = !at_target_i`. With `cfg_rdy_high_i=0` it is active-low, so `rdy_oe_o = at_target_i`. The output is registered, with one cycle of latency.
- R6: With `cfg_evt_sel_i=0`, a rising `fault_oe_o` copies the live channel faults into `status_o[3:2]` (bit 2 = channel 0, bit 3 = channel 1) within two cycles.
- R7: With `cfg_evt_sel_i=1`, a capture happens on a falling debounced ready pin, but only when `cfg_rdy_high_i=1` and the block is not itself driving the line. In active-low mode the pin is ignored. In this mode a rising `fault_oe_o` does not capture.
- R8: A capture happens only on the transition into the event condition. While the condition persists, changes of the channel states leave `status_o[3:2]` unchanged.
- R9: A one-cycle `latch_clr_i` sets `status_o[3:2]` to 0 on the next cycle.
- R10: During reset and after it, `fault_oe_o`, `rdy_oe_o`, `holdoff_en_o` and `status_o` are 0. No fault is reported until the synchronizer has filled with real samples.
- R11: A ready-pin low lasting a single cycle is rejected by the two-sample debouncer and causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 2 | Comparator outputs, 1 = input above reference (asynchronous) |
| cfg_ov_i | input | 2 | Per channel: 1 = overvoltage sense, 0 = undervoltage sense |
| cfg_mute_margin_i | input | 1 | Silence the fault line while margining high or low |
| cfg_evt_sel_i | input | 1 | Capture event: 0 = fault line asserts, 1 = ready line falls |
| cfg_rdy_high_i | input | 1 | Ready polarity: 1 = active-high (input use allowed), 0 = active-low |
| margin_state_i | input | 2 | 0 Off, 1 Nominal, 2 margin high, 3 margin low |
| at_target_i | input | 1 | Supply has reached its set point |
| rdy_pin_i | input | 1 | Sampled level of the shared ready line (asynchronous) |
| latch_clr_i | input | 1 | One-cycle strobe clearing the captured bits |
| fault_oe_o | output | 1 | 1 = pull the fault line low |
| rdy_oe_o | output | 1 | 1 = pull the ready line low |
| holdoff_en_o | output | 1 | Hold-off and shutdown control enabled |
| status_o | output | 4 | [1:0] live faults, [3:2] captured faults |

## Verification
The polarity logic is tried with all sixteen pairings of sense mode and comparator level. This separates a swapped channel, an inverted sense bit or a wrong OR of the two channels. The margin states are each combined with the silence bit set and clear, which shows whether the exemption covers exactly Off and Nominal. Capture is tried with a second channel joining an active fault, with a clear during a persisting event, with a one-cycle ready glitch against a held low, and with the ready pin pulled in active-low mode. These cases tell an edge-triggered capture apart from a level-triggered one, and show that the debouncer and the polarity gate work.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef enum logic [1:0] {
    MRG_OFF     = 2'd0,
    MRG_NOMINAL = 2'd1,
    MRG_HIGH    = 2'd2,
    MRG_LOW     = 2'd3
  } margin_e;

  typedef enum logic {
    EVT_FAULT = 1'b0,
    EVT_READY = 1'b1
  } evt_sel_e;

  function automatic logic is_margining(input margin_e m);
    return (m == MRG_HIGH) || (m == MRG_LOW);
  endfunction
endpackage

// File: rtl/sfm_sync.sv
module sfm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         primed_o
);
  logic [W-1:0]      stg [STAGES];
  logic [STAGES-1:0] fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      fill <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      fill <= {fill[STAGES-2:0], 1'b1};
    end
  end

  assign q_o      = stg[STAGES-1];
  assign primed_o = fill[STAGES-1];

  AST_PRIMED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    primed_o |=> primed_o); // R10
endmodule

// File: rtl/sfm_debounce.sv
module sfm_debounce #(
  parameter int   SAMPLES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic db_o
);
  logic [SAMPLES-1:0] smp;
  logic               all_hi, all_lo;

  assign all_hi = &smp;
  assign all_lo = ~|smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp  <= {SAMPLES{RST_VAL}};
      db_o <= RST_VAL;
    end else begin
      smp <= {smp[SAMPLES-2:0], d_i};
      if (all_hi)      db_o <= 1'b1;
      else if (all_lo) db_o <= 1'b0;
    end
  end

  AST_DB_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (db_o != $past(db_o)) |-> ($past(smp) == '0 || $past(smp) == '1)); // R11
endmodule

// File: rtl/sfm_fault_path.sv
module sfm_fault_path
  import sfm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cmp_s_i,
  input  logic              primed_i,
  input  logic [NUM_CH-1:0] cfg_ov_i,
  input  logic              cfg_mute_i,
  input  margin_e           margin_i,
  output logic [NUM_CH-1:0] live_o,
  output logic              fault_oe_o,
  output logic              holdoff_en_o
);
  logic [NUM_CH-1:0] chan_fault;
  logic              silenced;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chan_fault[c] = primed_i && (cfg_ov_i[c] ? cmp_s_i[c] : !cmp_s_i[c]);
  end

  assign silenced = cfg_mute_i && is_margining(margin_i);
  assign live_o   = chan_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_oe_o   <= 1'b0;
      holdoff_en_o <= 1'b0;
    end else begin
      fault_oe_o   <= (|chan_fault) && !silenced;
      holdoff_en_o <= (margin_i == MRG_NOMINAL);
    end
  end

  AST_SILENT_WHEN_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mute_i && is_margining(margin_i)) |=> !fault_oe_o); // R3
  AST_FAULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (live_o == '0) |=> !fault_oe_o); // R2
  AST_HOLDOFF_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    holdoff_en_o |-> ($past(margin_i) == MRG_NOMINAL)); // R4
endmodule

// File: rtl/sfm_latch.sv
module sfm_latch
  import sfm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  evt_sel_e          sel_i,
  input  logic              rdy_high_i,
  input  logic              rdy_oe_i,
  input  logic              rdy_db_i,
  input  logic              fault_oe_i,
  input  logic [NUM_CH-1:0] live_i,
  input  logic              clr_i,
  output logic [NUM_CH-1:0] held_o
);
  logic fault_prev, rdy_prev;
  logic fault_rise, rdy_fall, capture;

  assign fault_rise = fault_oe_i && !fault_prev;
  assign rdy_fall   = rdy_prev && !rdy_db_i && rdy_high_i && !rdy_oe_i;
  assign capture    = (sel_i == EVT_FAULT) ? fault_rise : rdy_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_prev <= 1'b0;
      rdy_prev   <= 1'b1;
      held_o     <= '0;
    end else begin
      fault_prev <= fault_oe_i;
      rdy_prev   <= rdy_db_i;
      if (capture)    held_o <= live_i;
      else if (clr_i) held_o <= '0;
    end
  end

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !clr_i) |=> $stable(held_o)); // R8
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !capture) |=> (held_o == '0)); // R9
  AST_LOW_POLARITY_IGNORES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == EVT_READY && !rdy_high_i && !clr_i) |=> $stable(held_o)); // R7
endmodule

// File: rtl/supply_fault_monitor.sv
module supply_fault_monitor
  import sfm_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DB_SAMPLES  = 2,
  localparam int STAT_W     = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cmp_i,
  input  logic [NUM_CH-1:0] cfg_ov_i,
  input  logic              cfg_mute_margin_i,
  input  logic              cfg_evt_sel_i,
  input  logic              cfg_rdy_high_i,
  input  logic [1:0]        margin_state_i,
  input  logic              at_target_i,
  input  logic              rdy_pin_i,
  input  logic              latch_clr_i,
  output logic              fault_oe_o,
  output logic              rdy_oe_o,
  output logic              holdoff_en_o,
  output logic [STAT_W-1:0] status_o
);
  logic [NUM_CH-1:0] cmp_s, live, held;
  logic [NUM_CH-1:0] live_q;
  logic              cmp_primed, rdy_s, rdy_primed, rdy_db;
  margin_e           margin;
  evt_sel_e          evt_sel;

  assign margin  = margin_e'(margin_state_i);
  assign evt_sel = evt_sel_e'(cfg_evt_sel_i);

  sfm_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_cmp_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(cmp_s), .primed_o(cmp_primed));

  sfm_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rdy_pin_i), .q_o(rdy_s), .primed_o(rdy_primed));

  sfm_debounce #(.SAMPLES(DB_SAMPLES), .RST_VAL(1'b1)) u_rdy_db (
    .clk(clk), .rst_n(rst_n), .d_i(rdy_s || !rdy_primed), .db_o(rdy_db));

  sfm_fault_path #(.NUM_CH(NUM_CH)) u_fault (
    .clk(clk), .rst_n(rst_n), .cmp_s_i(cmp_s), .primed_i(cmp_primed),
    .cfg_ov_i(cfg_ov_i), .cfg_mute_i(cfg_mute_margin_i), .margin_i(margin),
    .live_o(live), .fault_oe_o(fault_oe_o), .holdoff_en_o(holdoff_en_o));

  sfm_latch #(.NUM_CH(NUM_CH)) u_latch (
    .clk(clk), .rst_n(rst_n), .sel_i(evt_sel), .rdy_high_i(cfg_rdy_high_i),
    .rdy_oe_i(rdy_oe_o), .rdy_db_i(rdy_db), .fault_oe_i(fault_oe_o),
    .live_i(live), .clr_i(latch_clr_i), .held_o(held));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= '0;
      rdy_oe_o <= 1'b0;
    end else begin
      live_q   <= live;
      rdy_oe_o <= cfg_rdy_high_i ? !at_target_i : at_target_i;
    end
  end

  assign status_o = {held, live_q};

  AST_NO_FAULT_UNPRIMED: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_primed |=> !fault_oe_o); // R10
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_oe_o |-> ($past(live) != '0)); // R2
endmodule

// File: tb/supply_fault_monitor_bench.sv
module supply_fault_monitor_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cmp_i = 2'b11, cfg_ov_i = 2'b00, margin_state_i = 2'd1;
  logic       cfg_mute_margin_i = 1'b0, cfg_evt_sel_i = 1'b0, cfg_rdy_high_i = 1'b1;
  logic       at_target_i = 1'b1, rdy_pin_i = 1'b1, latch_clr_i = 1'b0;
  logic       fault_oe_o, rdy_oe_o, holdoff_en_o;
  logic [3:0] status_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_fault_monitor u_supply_fault_monitor (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp_i), .cfg_ov_i(cfg_ov_i),
    .cfg_mute_margin_i(cfg_mute_margin_i), .cfg_evt_sel_i(cfg_evt_sel_i),
    .cfg_rdy_high_i(cfg_rdy_high_i), .margin_state_i(margin_state_i),
    .at_target_i(at_target_i), .rdy_pin_i(rdy_pin_i), .latch_clr_i(latch_clr_i),
    .fault_oe_o(fault_oe_o), .rdy_oe_o(rdy_oe_o), .holdoff_en_o(holdoff_en_o),
    .status_o(status_o));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_live(input logic [1:0] ov, input logic [1:0] c);
    return ov ~^ c;
  endfunction

  task automatic pulse_clr();
    latch_clr_i = 1'b1;
    step(1);
    latch_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    step(2);
    check("R10", "fault_oe in reset", fault_oe_o, 0);
    check("R10", "rdy_oe in reset", rdy_oe_o, 0);
    check("R10", "status in reset", status_o, 0);
    rst_n = 1'b1;
    step(1);
    check("R10", "fault_oe before primed", fault_oe_o, 0);
    step(5);
    check("R10", "status after reset", status_o, 0);
    check("R10", "fault_oe after reset", fault_oe_o, 0);
  endtask

  task automatic t_polarity();
    cfg_evt_sel_i = 1'b0;
    for (int o = 0; o < 4; o++) begin
      for (int c = 0; c < 4; c++) begin
        cfg_ov_i = o[1:0];
        cmp_i    = c[1:0];
        step(4);
        check("R1", $sformatf("live ov=%0d cmp=%0d", o, c), status_o[1:0],
              exp_live(o[1:0], c[1:0]));
        check("R2", $sformatf("fault ov=%0d cmp=%0d", o, c), fault_oe_o,
              |exp_live(o[1:0], c[1:0]));
      end
    end
    cfg_ov_i = 2'b00; cmp_i = 2'b11;
    step(4);
    check("R2", "released", fault_oe_o, 0);
  endtask

  task automatic t_mute();
    cfg_ov_i = 2'b00; cmp_i = 2'b10;
    cfg_mute_margin_i = 1'b1;
    for (int m = 0; m < 4; m++) begin
      margin_state_i = m[1:0];
      step(4);
      check("R3", $sformatf("mute margin=%0d", m), fault_oe_o, (m < 2) ? 1 : 0);
      check("R3", $sformatf("live under mute margin=%0d", m), status_o[1:0], 2'b01);
    end
    cfg_mute_margin_i = 1'b0;
    margin_state_i = 2'd2;
    step(3);
    check("R3", "no mute bit, margin high", fault_oe_o, 1);
    cmp_i = 2'b11; margin_state_i = 2'd1;
    step(4);
  endtask

  task automatic t_holdoff();
    for (int m = 0; m < 4; m++) begin
      margin_state_i = m[1:0];
      step(2);
      check("R4", $sformatf("holdoff margin=%0d", m), holdoff_en_o, (m == 1) ? 1 : 0);
    end
    margin_state_i = 2'd1;
  endtask

  task automatic t_ready_out();
    for (int p = 0; p < 2; p++) begin
      for (int a = 0; a < 2; a++) begin
        cfg_rdy_high_i = p[0];
        at_target_i    = a[0];
        step(2);
        check("R5", $sformatf("rdy_oe high=%0d target=%0d", p, a), rdy_oe_o,
              p[0] ? !a[0] : a[0]);
      end
    end
    cfg_rdy_high_i = 1'b1; at_target_i = 1'b1;
    step(2);
  endtask

  task automatic t_latch_fault();
    cfg_evt_sel_i = 1'b0; cfg_ov_i = 2'b00; cmp_i = 2'b11;
    step(4);
    pulse_clr();
    step(1);
    check("R9", "cleared before test", status_o[3:2], 0);
    cmp_i = 2'b10;
    step(6);
    check("R6", "captured ch0 on fault rise", status_o[3:2], 2'b01);
    cmp_i = 2'b00;
    step(6);
    check("R8", "second channel joins, no recapture", status_o[3:2], 2'b01);
    pulse_clr();
    step(1);
    check("R9", "clear during persisting fault", status_o[3:2], 0);
    step(4);
    check("R8", "no capture while fault persists", status_o[3:2], 0);
    cmp_i = 2'b11;
    step(6);
    cmp_i = 2'b01;
    step(6);
    check("R6", "captured ch1 on new rise", status_o[3:2], 2'b10);
  endtask

  task automatic t_latch_ready();
    cfg_evt_sel_i = 1'b1; cfg_rdy_high_i = 1'b1; at_target_i = 1'b1;
    cmp_i = 2'b11;
    step(6);
    pulse_clr();
    cmp_i = 2'b01;
    step(6);
    check("R7", "fault rise ignored in ready mode", status_o[3:2], 0);
    rdy_pin_i = 1'b0;
    step(1);
    rdy_pin_i = 1'b1;
    step(8);
    check("R11", "one-cycle glitch rejected", status_o[3:2], 0);
    rdy_pin_i = 1'b0;
    step(8);
    check("R7", "captured on ready falling", status_o[3:2], 2'b10);
    cmp_i = 2'b00;
    step(6);
    check("R8", "held low, no recapture", status_o[3:2], 2'b10);
    rdy_pin_i = 1'b1;
    step(8);
    cfg_rdy_high_i = 1'b0; at_target_i = 1'b0;
    step(2);
    pulse_clr();
    rdy_pin_i = 1'b0;
    step(8);
    check("R7", "pin ignored in active-low mode", status_o[3:2], 0);
    rdy_pin_i = 1'b1;
    step(8);
  endtask

  initial begin
    t_reset();
    t_polarity();
    t_mute();
    t_holdoff();
    t_ready_out();
    t_latch_fault();
    t_latch_ready();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule